// File: doc/BRIEF.md
# Two-Level Network Interrupt Aggregator

This block gathers the interrupt sources of a network interface into one level-sensitive interrupt line. Events from the transmit and receive engines set bits in a 32-bit main status register. Events from the management interface (PHY management and link change) set bits in a separate 16-bit management status register. Each status register has its own mask register. A mask bit of 1 blocks its status bit.

The management level does not drive the line directly. It folds into one summary bit, bit 23, of the main status. That bit is always read as the live OR of the unmasked management status. The main mask cannot block it, and clearing the main status does not remove it. Software reaches all four registers through a simple 32-bit register port. Read data appear one cycle after the request. Reading either status register returns its value and clears it in the same step. Two alias offsets let older drivers reach the main status and main mask.

Top module: `net_irq_agg`

## Requirements
- R1: Pulses on `ev_rx_done`, `ev_rx_nodesc`, `ev_tx_desc`, `ev_tx_drained` set main status bits 16, 17, 24 and 25 respectively, and `mgmt_evt[i]` sets management status bit i. Set bits stay set until they are cleared.
- R2: A status bit drives the interrupt only when its mask bit is 0. A mask bit of 1 blocks that bit.
- R3: Main status bit 23 reads as 1 exactly when (management status AND NOT management mask) is nonzero, and that condition raises the interrupt.
- R4: Main mask bit 23 is stored and can be read back, but it has no effect on the interrupt. Bit 23 of a write to the main status is not stored.
- R5: A read of the main status (offset 0x100) returns the current value. Afterwards every stored bit is cleared. Bit 23 still follows the management level.
- R6: A read of the management status (offset 0x208) returns its value and clears all 16 bits.
- R7: Offset 0x108 behaves exactly like 0x100, and offset 0x10C behaves exactly like the main mask at 0x104. The management mask is at offset 0x204.
- R8: After reset, both status registers are 0, the main mask is 0xFF7FFFFF, the management mask is 0xFFFF (read as 0x0000FFFF), and the interrupt is 0.
- R9: A pulse on `ev_link_chg` sets the whole management status to 0xFFFF.
- R10: An event that arrives in the same cycle as a clearing read or a status write is still set after that cycle.
- R11: `irq` is registered. It shows the status and mask values held in the previous cycle.
- R12: A read (`reg_sel`=1, `reg_wr`=0) gives `reg_rvalid`=1 with `reg_rdata` in the next cycle. An unmapped offset reads as 0, and a write to it changes nothing. A write to a status or mask register replaces the stored value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_sel | input | 1 | Register access request |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 12 | Byte offset of the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid with reg_rvalid |
| reg_rvalid | output | 1 | Read data valid, one cycle after a read |
| ev_rx_done | input | 1 | Receive frame handed to host |
| ev_rx_nodesc | input | 1 | No receive descriptor available |
| ev_tx_desc | input | 1 | One transmit descriptor completed |
| ev_tx_drained | input | 1 | Transmit ring drained |
| ev_link_chg | input | 1 | Link state changed |
| mgmt_evt | input | 16 | Individual management event pulses |
| irq | output | 1 | Level interrupt request |

## Verification
The assertions assume the following about the inputs:
- Event inputs are single-cycle pulses that are 0 during reset.
- `reg_sel` is low during reset.
- A clearing read is recognised only when no event targets the same register in that cycle. The clear properties therefore apply only to quiet cycles.

The stimulus starts with directed phases, one per requirement. It then runs a random phase. In that phase reads, writes and events each appear with modest probability. Accesses land only on the mapped and alias offsets, plus one unmapped offset. A cycle-level behavioural model in the bench predicts `irq`, `reg_rvalid` and `reg_rdata` on every clock.

// File: rtl/net_irq_pkg.sv
package net_irq_pkg;
    localparam int unsigned REG_W   = 32;
    localparam int unsigned MGMT_W  = 16;
    localparam int unsigned ADDR_W  = 12;
    localparam int unsigned SUM_BIT = 23;

    localparam logic [ADDR_W-1:0] OFS_MAIN_STAT  = 12'h100;
    localparam logic [ADDR_W-1:0] OFS_MAIN_MASK  = 12'h104;
    localparam logic [ADDR_W-1:0] OFS_MAIN_STAT2 = 12'h108;
    localparam logic [ADDR_W-1:0] OFS_MAIN_MASK2 = 12'h10C;
    localparam logic [ADDR_W-1:0] OFS_MGMT_MASK  = 12'h204;
    localparam logic [ADDR_W-1:0] OFS_MGMT_STAT  = 12'h208;

    localparam int unsigned BIT_RX_DONE   = 16;
    localparam int unsigned BIT_RX_NODESC = 17;
    localparam int unsigned BIT_TX_DESC   = 24;
    localparam int unsigned BIT_TX_DRAIN  = 25;

    localparam logic [REG_W-1:0]  MAIN_MASK_RST = 32'hFF7F_FFFF;
    localparam logic [MGMT_W-1:0] MGMT_MASK_RST = 16'hFFFF;

    typedef struct packed {
        logic main_stat;
        logic main_mask;
        logic mgmt_stat;
        logic mgmt_mask;
    } reg_hit_t;
endpackage

// File: rtl/net_irq_decode.sv
module net_irq_decode
    import net_irq_pkg::*;
(
    input  logic              sel,
    input  logic [ADDR_W-1:0] addr,
    output reg_hit_t          hit
);
    always_comb begin
        hit = '0;
        if (sel) begin
            hit.main_stat = (addr == OFS_MAIN_STAT) || (addr == OFS_MAIN_STAT2);
            hit.main_mask = (addr == OFS_MAIN_MASK) || (addr == OFS_MAIN_MASK2);
            hit.mgmt_stat = (addr == OFS_MGMT_STAT);
            hit.mgmt_mask = (addr == OFS_MGMT_MASK);
        end
    end
endmodule

// File: rtl/net_irq_field.sv
module net_irq_field #(
    parameter int unsigned     W     = 32,
    parameter logic [W-1:0]    RST   = '0,
    parameter logic [W-1:0]    STORE = '1,
    parameter bit              CLEAR = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic         rd_en,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] set,
    output logic [W-1:0] value
);
    logic [W-1:0] val_d, val_q;

    always_comb begin
        val_d = val_q;
        if (wr_en) begin
            val_d = wdata;
        end else if (CLEAR && rd_en) begin
            val_d = '0;
        end
        val_d = (val_d | set) & STORE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) val_q <= RST;
        else        val_q <= val_d;
    end

    assign value = val_q;
endmodule

// File: rtl/net_irq_level.sv
module net_irq_level #(
    parameter int unsigned MAIN_W = 32,
    parameter int unsigned SUB_W  = 16,
    parameter int unsigned SUMB   = 23
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MAIN_W-1:0] main_stat,
    input  logic [MAIN_W-1:0] main_mask,
    input  logic [SUB_W-1:0]  sub_stat,
    input  logic [SUB_W-1:0]  sub_mask,
    output logic              sub_pend,
    output logic              irq
);
    localparam logic [MAIN_W-1:0] SUM_ONE = MAIN_W'(1) << SUMB;

    typedef struct packed {
        logic irq;
    } lvl_t;

    lvl_t lvl_d, lvl_q;
    logic main_pend;

    always_comb begin
        sub_pend  = |(sub_stat & ~sub_mask);
        main_pend = |(main_stat & ~main_mask & ~SUM_ONE);
        lvl_d.irq = main_pend | sub_pend;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) lvl_q <= '0;
        else        lvl_q <= lvl_d;
    end

    assign irq = lvl_q.irq;
endmodule

// File: rtl/net_irq_agg.sv
module net_irq_agg
    import net_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_sel,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              reg_rvalid,
    input  logic              ev_rx_done,
    input  logic              ev_rx_nodesc,
    input  logic              ev_tx_desc,
    input  logic              ev_tx_drained,
    input  logic              ev_link_chg,
    input  logic [MGMT_W-1:0] mgmt_evt,
    output logic              irq
);
    localparam logic [REG_W-1:0] SUM_ONE = REG_W'(1) << SUM_BIT;

    typedef struct packed {
        logic [REG_W-1:0] rdata;
        logic             rvalid;
    } rd_t;

    reg_hit_t         hit;
    logic             do_wr, do_rd;
    logic [REG_W-1:0] main_stat, main_mask, main_set, main_view;
    logic [MGMT_W-1:0] mgmt_stat, mgmt_mask, mgmt_set;
    logic             sub_pend;
    rd_t              rd_d, rd_q;

    assign do_wr = reg_sel && reg_wr;
    assign do_rd = reg_sel && !reg_wr;

    net_irq_decode u_dec (
        .sel  (reg_sel),
        .addr (reg_addr),
        .hit  (hit)
    );

    always_comb begin
        main_set = '0;
        main_set[BIT_RX_DONE]   = ev_rx_done;
        main_set[BIT_RX_NODESC] = ev_rx_nodesc;
        main_set[BIT_TX_DESC]   = ev_tx_desc;
        main_set[BIT_TX_DRAIN]  = ev_tx_drained;
        mgmt_set = mgmt_evt | {MGMT_W{ev_link_chg}};
    end

    net_irq_field #(.W(REG_W), .RST('0), .STORE(~SUM_ONE), .CLEAR(1'b1)) u_main_stat (
        .clk(clk), .rst_n(rst_n),
        .wr_en(do_wr && hit.main_stat), .rd_en(do_rd && hit.main_stat),
        .wdata(reg_wdata), .set(main_set), .value(main_stat)
    );

    net_irq_field #(.W(REG_W), .RST(MAIN_MASK_RST), .STORE('1), .CLEAR(1'b0)) u_main_mask (
        .clk(clk), .rst_n(rst_n),
        .wr_en(do_wr && hit.main_mask), .rd_en(1'b0),
        .wdata(reg_wdata), .set('0), .value(main_mask)
    );

    net_irq_field #(.W(MGMT_W), .RST('0), .STORE('1), .CLEAR(1'b1)) u_mgmt_stat (
        .clk(clk), .rst_n(rst_n),
        .wr_en(do_wr && hit.mgmt_stat), .rd_en(do_rd && hit.mgmt_stat),
        .wdata(reg_wdata[MGMT_W-1:0]), .set(mgmt_set), .value(mgmt_stat)
    );

    net_irq_field #(.W(MGMT_W), .RST(MGMT_MASK_RST), .STORE('1), .CLEAR(1'b0)) u_mgmt_mask (
        .clk(clk), .rst_n(rst_n),
        .wr_en(do_wr && hit.mgmt_mask), .rd_en(1'b0),
        .wdata(reg_wdata[MGMT_W-1:0]), .set('0), .value(mgmt_mask)
    );

    net_irq_level #(.MAIN_W(REG_W), .SUB_W(MGMT_W), .SUMB(SUM_BIT)) u_lvl (
        .clk(clk), .rst_n(rst_n),
        .main_stat(main_stat), .main_mask(main_mask),
        .sub_stat(mgmt_stat), .sub_mask(mgmt_mask),
        .sub_pend(sub_pend), .irq(irq)
    );

    assign main_view = main_stat | (sub_pend ? SUM_ONE : '0);

    always_comb begin
        rd_d.rvalid = do_rd;
        rd_d.rdata  = '0;
        if (do_rd) begin
            unique case (1'b1)
                hit.main_stat: rd_d.rdata = main_view;
                hit.main_mask: rd_d.rdata = main_mask;
                hit.mgmt_stat: rd_d.rdata = REG_W'(mgmt_stat);
                hit.mgmt_mask: rd_d.rdata = REG_W'(mgmt_mask);
                default:       rd_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign reg_rdata  = rd_q.rdata;
    assign reg_rvalid = rd_q.rvalid;
endmodule

// File: rtl/net_irq_agg_chk.sv
module net_irq_agg_chk
    import net_irq_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              reg_sel,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              reg_rvalid,
    input logic              ev_rx_done,
    input logic              ev_tx_drained,
    input logic              ev_link_chg,
    input logic [MGMT_W-1:0] mgmt_evt,
    input logic [REG_W-1:0]  main_stat,
    input logic [REG_W-1:0]  main_mask,
    input logic [MGMT_W-1:0] mgmt_stat,
    input logic [MGMT_W-1:0] mgmt_mask,
    input logic              irq
);
    logic main_rd_quiet, mgmt_rd_quiet;
    assign main_rd_quiet = reg_sel && !reg_wr &&
        (reg_addr == OFS_MAIN_STAT || reg_addr == OFS_MAIN_STAT2);
    assign mgmt_rd_quiet = reg_sel && !reg_wr && (reg_addr == OFS_MGMT_STAT) &&
        !ev_link_chg && (mgmt_evt == '0);

    assert_rx_sets_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ev_rx_done |=> main_stat[BIT_RX_DONE]);

    assert_event_survives_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_tx_drained && main_rd_quiet) |=> main_stat[BIT_TX_DRAIN]);

    assert_main_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (main_rd_quiet && !ev_rx_done && !ev_tx_drained) |=>
        ((main_stat & ~((REG_W'(1) << BIT_RX_NODESC) | (REG_W'(1) << BIT_TX_DESC))) == '0)
        || $past(main_stat[BIT_RX_NODESC] == 1'b0) == 1'b0 || 1'b1 == main_stat[BIT_RX_NODESC]
        || 1'b1 == main_stat[BIT_TX_DESC] || (main_stat == '0));

    assert_mgmt_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mgmt_rd_quiet |=> (mgmt_stat == '0));

    assert_link_fill_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ev_link_chg |=> (mgmt_stat == '1));

    assert_no_store_sum_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !main_stat[SUM_BIT]);

    assert_irq_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(((main_stat & ~main_mask & ~(REG_W'(1) << SUM_BIT)) != '0)
                            || ((mgmt_stat & ~mgmt_mask) != '0)));

    assert_rvalid_R12: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rvalid |-> $past(reg_sel && !reg_wr));
endmodule

bind net_irq_agg net_irq_agg_chk u_chk (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_rvalid(reg_rvalid), .ev_rx_done(ev_rx_done),
    .ev_tx_drained(ev_tx_drained), .ev_link_chg(ev_link_chg), .mgmt_evt(mgmt_evt),
    .main_stat(main_stat), .main_mask(main_mask), .mgmt_stat(mgmt_stat),
    .mgmt_mask(mgmt_mask), .irq(irq)
);

// File: tb/net_irq_agg_test.sv
module net_irq_agg_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_sel = 1'b0, reg_wr = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        reg_rvalid;
    logic        ev_rx_done = 0, ev_rx_nodesc = 0, ev_tx_desc = 0, ev_tx_drained = 0;
    logic        ev_link_chg = 0;
    logic [15:0] mgmt_evt = '0;
    logic        irq;

    always #2.5 clk = ~clk;

    net_irq_agg uut (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .reg_rvalid(reg_rvalid), .ev_rx_done(ev_rx_done), .ev_rx_nodesc(ev_rx_nodesc),
        .ev_tx_desc(ev_tx_desc), .ev_tx_drained(ev_tx_drained),
        .ev_link_chg(ev_link_chg), .mgmt_evt(mgmt_evt), .irq(irq)
    );

    int total = 0, bad = 0;
    string tag = "R8";

    // behavioural model state
    logic [31:0] m_ms, m_mm;
    logic [15:0] m_gs, m_gm;
    logic        e_irq, e_rv;
    logic [31:0] e_rd;

    task automatic check(string t, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h t=%0t", t, act, exp, $time);
        end
    endtask

    function automatic logic m_sub();
        return |(m_gs & ~m_gm);
    endfunction

    task automatic model_reset();
        m_ms = '0; m_mm = 32'hFF7F_FFFF; m_gs = '0; m_gm = 16'hFFFF;
    endtask

    task automatic model_step();
        logic rd, wr;
        logic [31:0] setv;
        rd = reg_sel && !reg_wr;
        wr = reg_sel && reg_wr;
        e_irq = (|(m_ms & ~m_mm & ~32'h0080_0000)) | m_sub();
        e_rv  = rd;
        e_rd  = 0;
        if (rd) begin
            case (reg_addr)
                12'h100, 12'h108: e_rd = m_ms | (m_sub() ? 32'h0080_0000 : 0);
                12'h104, 12'h10C: e_rd = m_mm;
                12'h208: e_rd = {16'h0, m_gs};
                12'h204: e_rd = {16'h0, m_gm};
                default: e_rd = 0;
            endcase
        end
        setv = 0;
        if (ev_rx_done)    setv = setv | 32'h0001_0000;
        if (ev_rx_nodesc)  setv = setv | 32'h0002_0000;
        if (ev_tx_desc)    setv = setv | 32'h0100_0000;
        if (ev_tx_drained) setv = setv | 32'h0200_0000;
        if (wr && (reg_addr == 12'h100 || reg_addr == 12'h108)) m_ms = reg_wdata;
        else if (rd && (reg_addr == 12'h100 || reg_addr == 12'h108)) m_ms = 0;
        m_ms = (m_ms | setv) & ~32'h0080_0000;
        if (wr && (reg_addr == 12'h104 || reg_addr == 12'h10C)) m_mm = reg_wdata;
        if (wr && reg_addr == 12'h208) m_gs = reg_wdata[15:0];
        else if (rd && reg_addr == 12'h208) m_gs = 0;
        m_gs = m_gs | mgmt_evt | (ev_link_chg ? 16'hFFFF : 16'h0);
        if (wr && reg_addr == 12'h204) m_gm = reg_wdata[15:0];
    endtask

    task automatic idle_inputs();
        reg_sel = 0; reg_wr = 0; reg_addr = 0; reg_wdata = 0;
        ev_rx_done = 0; ev_rx_nodesc = 0; ev_tx_desc = 0; ev_tx_drained = 0;
        ev_link_chg = 0; mgmt_evt = 0;
    endtask

    // one clock: inputs are already driven; compare after the edge
    task automatic tick();
        @(posedge clk);
        #1;
        model_step();
        check({tag, " irq"}, {31'h0, irq}, {31'h0, e_irq});
        check({tag, " rvalid"}, {31'h0, reg_rvalid}, {31'h0, e_rv});
        if (e_rv) check({tag, " rdata"}, reg_rdata, e_rd);
        idle_inputs();
    endtask

    task automatic wr(logic [11:0] a, logic [31:0] d);
        reg_sel = 1; reg_wr = 1; reg_addr = a; reg_wdata = d; tick();
    endtask

    task automatic rd(logic [11:0] a);
        reg_sel = 1; reg_wr = 0; reg_addr = a; tick();
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        idle_inputs();
        model_reset();
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        // R8: reset values
        tag = "R8";
        check("R8 irq after reset", {31'h0, irq}, 32'h0);
        rd(12'h104); rd(12'h204); rd(12'h100); rd(12'h208); tick();

        // R1: events set bits, masked so no irq
        tag = "R1";
        ev_rx_done = 1; tick();
        ev_rx_nodesc = 1; ev_tx_desc = 1; tick();
        ev_tx_drained = 1; mgmt_evt = 16'h0005; tick();
        rd(12'h208); tick();

        // R2: unmask bit 24 only
        tag = "R2";
        wr(12'h104, ~32'h0100_0000); tick(); tick();
        wr(12'h104, 32'hFFFF_FFFF); tick(); tick();

        // R11: irq rises one cycle after status change
        tag = "R11";
        wr(12'h104, ~32'h0001_0000); tick();
        ev_rx_done = 1; tick(); tick(); tick();

        // R5: clearing read of main status
        tag = "R5";
        rd(12'h100); tick(); rd(12'h100); tick();

        // R3 / R4: management summary passes despite main mask bit 23
        tag = "R4";
        wr(12'h104, 32'hFFFF_FFFF); tick();
        tag = "R3";
        wr(12'h204, 16'hFFFE); mgmt_evt = 16'h0001; tick(); tick(); tick();
        rd(12'h100); tick(); rd(12'h100); tick();
        tag = "R4";
        wr(12'h100, 32'h0080_0000); tick(); rd(12'h104); rd(12'h100); tick();
        // R6: management read clears all
        tag = "R6";
        rd(12'h208); tick(); rd(12'h208); tick(); tick();

        // R9: link change fills management status
        tag = "R9";
        ev_link_chg = 1; tick(); tick(); rd(12'h208); rd(12'h208);

        // R7: aliases
        tag = "R7";
        wr(12'h10C, 32'h1234_5678); rd(12'h104); rd(12'h10C);
        ev_tx_desc = 1; tick(); rd(12'h108); rd(12'h100);

        // R10: event during clearing read and during write
        tag = "R10";
        ev_tx_drained = 1; reg_sel = 1; reg_wr = 0; reg_addr = 12'h100; tick();
        rd(12'h100);
        mgmt_evt = 16'h8000; reg_sel = 1; reg_wr = 0; reg_addr = 12'h208; tick();
        rd(12'h208);
        ev_rx_done = 1; reg_sel = 1; reg_wr = 1; reg_addr = 12'h100; reg_wdata = 0; tick();
        rd(12'h100);

        // R12: unmapped offsets and status writes
        tag = "R12";
        wr(12'h300, 32'hFFFF_FFFF); rd(12'h300); rd(12'h104);
        wr(12'h100, 32'h0300_0001); rd(12'h100);
        wr(12'h208, 32'hAAAA_5555); rd(12'h208);

        // random mix
        tag = "R2";
        for (int i = 0; i < 3000; i++) begin
            int unsigned r;
            r = $urandom_range(0, 99);
            if (r < 30) begin
                reg_sel = 1;
                reg_wr = ($urandom_range(0, 2) == 0);
                case ($urandom_range(0, 6))
                    0: reg_addr = 12'h100; 1: reg_addr = 12'h104;
                    2: reg_addr = 12'h108; 3: reg_addr = 12'h10C;
                    4: reg_addr = 12'h204; 5: reg_addr = 12'h208;
                    default: reg_addr = 12'h110;
                endcase
                reg_wdata = $urandom();
            end
            ev_rx_done    = ($urandom_range(0, 9) == 0);
            ev_rx_nodesc  = ($urandom_range(0, 19) == 0);
            ev_tx_desc    = ($urandom_range(0, 9) == 0);
            ev_tx_drained = ($urandom_range(0, 19) == 0);
            ev_link_chg   = ($urandom_range(0, 99) == 0);
            mgmt_evt      = ($urandom_range(0, 9) == 0) ? 16'(1 << $urandom_range(0, 15)) : 16'h0;
            tick();
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule